// File: doc/BRIEF.md
# Programmable-Priority Interrupt Arbiter

This block sits between a set of interrupt sources and the execution unit of a processor. It watches a group of hardware request lines and a small group of software-posted requests, and it picks one winner among those that are pending. Every source has its own 4-bit priority register that software writes. The winner's level is compared with the priority mask that the running code carries in its status word. A single request, with the winner's vector index and level, is raised only when the winner's level is strictly above that mask.

Software interrupts are posted and withdrawn through two write-only registers. An interrupt service routine running at a high level can post a software interrupt whose programmed level is lower than its own. The deferred part of its work then runs only once the level drops, so no lower-level code has to wait behind it. Hardware sources are chosen at build time as edge-type or level-type. The execution unit acknowledges the request it takes, and that acknowledge withdraws an edge-type or software request.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, irq_req is 0, irq_vec is 0 and irq_lvl is 0. Every priority register is 0 and no software interrupt is posted.
- R2: A write with reg_addr = i, for i from 0 to N_SRC-1, loads reg_wdata[3:0] into the priority of source i. Hardware source h has index h. Software interrupt j has index N_HW+j.
- R3: A source whose priority is 0 never wins. When no pending source has a nonzero priority, irq_vec and irq_lvl are both 0 and irq_req is 0.
- R4: Among pending sources with nonzero priority, the one with the highest priority wins. When priorities are equal, the lowest index wins. irq_vec carries the winner's index and irq_lvl carries its priority.
- R5: irq_req is 1 only when the winner's level is strictly greater than psw_mask. irq_vec and irq_lvl show the winner even when the request is masked.
- R6: A level-type hardware source is pending exactly while its input is 1. An acknowledge does not remove it.
- R7: An edge-type hardware source becomes pending on a 0-to-1 transition of its input. It stays pending after the input falls, until it is acknowledged.
- R8: A write to reg_addr = N_SRC posts every software interrupt whose bit in reg_wdata is 1. A write to reg_addr = N_SRC+1 withdraws every software interrupt whose bit in reg_wdata is 1.
- R9: An ack sampled while irq_req is 1 withdraws the source named by irq_vec in the same edge, if it is edge-type or software. An ack while irq_req is 0 has no effect. A new rising edge or a post in the same edge as the ack keeps that source pending.
- R10: irq_req, irq_vec and irq_lvl are registered. Changes on the request inputs, the acknowledge, psw_mask and the software post and withdraw writes show up at the first clock edge that samples them. A priority write shows up one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_irq | input | N_HW | Hardware request lines, synchronous to clk |
| psw_mask | input | 4 | Priority of the running code, from the status word |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| ack | input | 1 | Acknowledge of the current request by the execution unit |
| irq_req | output | 1 | Request to the execution unit |
| irq_vec | output | VEC_W | Index of the winning source |
| irq_lvl | output | 4 | Priority of the winning source |

## Verification
Request inputs, acknowledges, the mask and software post or withdraw writes all update the outputs at the same clock edge that samples them. A priority write takes one more edge, because the new value has to sit in its register before arbitration can use it. The driver applies every stimulus on a falling edge and queues the result expected at the next rising edge. After each priority write it lets one edge pass unchecked before it queues anything. The monitor compares two nanoseconds after each rising edge, so every comparison falls exactly on the cycle the result is due and never on a clock edge.

// File: rtl/irq_arb_pkg.sv
// Package irq_arb_pkg
// Holds the shared priority width and the priority type for the arbiter.
// Assumes 4-bit priorities everywhere; the value 0 means "disabled".
package irq_arb_pkg;
    localparam int PRIO_W = 4;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/irq_hw_pending.sv
// Module irq_hw_pending
// Produces the effective pending state of each hardware source for this cycle.
// Edge-type sources latch a rising edge and are cleared by an acknowledge that
// names them. Level-type sources follow their input. EDGE_MASK bit h picks
// edge-type for source h. Assumes hw_irq is already synchronous to clk.
module irq_hw_pending #(
    parameter int               N_HW      = 8,
    parameter int               VEC_W     = 4,
    parameter logic [N_HW-1:0]  EDGE_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_HW-1:0]  hw_irq,
    input  logic             ack_fire,
    input  logic [VEC_W-1:0] ack_vec,
    output logic [N_HW-1:0]  pend_eff
);
    for (genvar g = 0; g < N_HW; g++) begin : g_src
        if (EDGE_MASK[g]) begin : g_edge
            logic prev_q;
            logic pend_q;
            logic hit;
            logic nxt;

            // Acknowledge aimed at this source; a fresh rising edge wins over it.
            assign hit = ack_fire && (ack_vec == VEC_W'(g));
            assign nxt = (pend_q && !hit) || (hw_irq[g] && !prev_q);

            // Keep the last input level and the latched request.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    prev_q <= hw_irq[g];
                    pend_q <= nxt;
                end
            end
            assign pend_eff[g] = nxt;
        end else begin : g_level
            assign pend_eff[g] = hw_irq[g];
        end
    end
endmodule

// File: rtl/irq_prio_regs.sv
// Module irq_prio_regs
// Holds the per-source priority registers and the software-interrupt post bits.
// Address i < N_SRC writes the priority of source i. Address N_SRC posts
// software interrupts and address N_SRC+1 withdraws them. Software interrupt j
// has source index N_HW+j. Assumes DATA_W >= PRIO_W and DATA_W >= N_SW.
module irq_prio_regs
    import irq_arb_pkg::*;
#(
    parameter int N_HW   = 8,
    parameter int N_SW   = 4,
    parameter int VEC_W  = 4,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_we,
    input  logic [DATA_W-1:0]             reg_wdata,
    input  logic                          ack_fire,
    input  logic [VEC_W-1:0]              ack_vec,
    output logic [N_HW+N_SW-1:0][PRIO_W-1:0] prio,
    output logic [N_SW-1:0]               sw_eff
);
    localparam int N_SRC    = N_HW + N_SW;
    localparam int SET_ADDR = N_SRC;
    localparam int CLR_ADDR = N_SRC + 1;

    logic [N_SW-1:0] sw_q;
    logic [N_SW-1:0] set_bits;
    logic [N_SW-1:0] clr_bits;
    logic [N_SW-1:0] ack_bits;

    // Decode the post and withdraw writes.
    always_comb begin
        set_bits = '0;
        clr_bits = '0;
        if (reg_we && reg_addr == ADDR_W'(SET_ADDR)) set_bits = reg_wdata[N_SW-1:0];
        if (reg_we && reg_addr == ADDR_W'(CLR_ADDR)) clr_bits = reg_wdata[N_SW-1:0];
    end

    // Decode an acknowledge that names a software interrupt.
    always_comb begin
        for (int j = 0; j < N_SW; j++) begin
            ack_bits[j] = ack_fire && (ack_vec == VEC_W'(N_HW + j));
        end
    end

    assign sw_eff = (sw_q & ~clr_bits & ~ack_bits) | set_bits;

    // Keep the posted software interrupts.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= sw_eff;
    end

    // Load the priority register that a write addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio <= '0;
        end else if (reg_we) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (reg_addr == ADDR_W'(i)) prio[i] <= reg_wdata[PRIO_W-1:0];
            end
        end
    end
endmodule

// File: rtl/irq_select.sv
// Module irq_select
// Finds the pending source with the highest nonzero priority. On equal
// priorities the lowest index wins. With no candidate it returns index 0 and
// level 0. Purely combinational.
module irq_select
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 12,
    parameter int VEC_W = 4
) (
    input  logic [N_SRC-1:0]             pend,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
    output logic [VEC_W-1:0]             best_idx,
    output prio_t                        best_lvl
);
    // Scan from the top index down so that a lower index takes ties.
    always_comb begin
        best_idx = '0;
        best_lvl = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i] && prio[i] != '0 && prio[i] >= best_lvl) begin
                best_idx = VEC_W'(i);
                best_lvl = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Module irq_arbiter (top)
// Arbitrates hardware and software interrupt sources by programmable priority
// and raises a registered request when the winner outranks psw_mask.
// An acknowledge is honoured only while irq_req is high, and it names the
// source on irq_vec. Assumes all inputs are synchronous to clk.
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int              N_HW      = 8,
    parameter int              N_SW      = 4,
    parameter logic [N_HW-1:0] EDGE_MASK = 8'h0F,
    parameter int              ADDR_W    = 5,
    parameter int              DATA_W    = 4,
    parameter int              N_SRC     = N_HW + N_SW,
    parameter int              VEC_W     = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_HW-1:0]   hw_irq,
    input  logic [PRIO_W-1:0] psw_mask,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              ack,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [PRIO_W-1:0] irq_lvl
);
    logic                          ack_fire;
    logic [N_HW-1:0]               hw_pend;
    logic [N_SW-1:0]               sw_pend;
    logic [N_SRC-1:0][PRIO_W-1:0]  prio;
    logic [VEC_W-1:0]              best_idx;
    prio_t                         best_lvl;

    assign ack_fire = ack && irq_req;

    irq_hw_pending #(
        .N_HW      (N_HW),
        .VEC_W     (VEC_W),
        .EDGE_MASK (EDGE_MASK)
    ) u_hw (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_irq   (hw_irq),
        .ack_fire (ack_fire),
        .ack_vec  (irq_vec),
        .pend_eff (hw_pend)
    );

    irq_prio_regs #(
        .N_HW   (N_HW),
        .N_SW   (N_SW),
        .VEC_W  (VEC_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .ack_fire  (ack_fire),
        .ack_vec   (irq_vec),
        .prio      (prio),
        .sw_eff    (sw_pend)
    );

    irq_select #(
        .N_SRC (N_SRC),
        .VEC_W (VEC_W)
    ) u_sel (
        .pend     ({sw_pend, hw_pend}),
        .prio     (prio),
        .best_idx (best_idx),
        .best_lvl (best_lvl)
    );

    // Register the winner and gate the request against the running mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_vec <= '0;
            irq_lvl <= '0;
        end else begin
            irq_req <= (best_lvl != '0) && (best_lvl > psw_mask);
            irq_vec <= best_idx;
            irq_lvl <= best_lvl;
        end
    end
endmodule

// File: rtl/irq_arb_chk.sv
// Module irq_arb_chk
// Property checks on the arbiter outputs, bound into every irq_arbiter.
module irq_arb_chk #(
    parameter int N_SRC = 12,
    parameter int VEC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       psw_mask,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic [3:0]       irq_lvl
);
    AST_REQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl > $past(psw_mask)));                        // R5
    AST_REQ_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl != 4'd0));                                  // R3
    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(irq_vec) < N_SRC);                                          // R4
    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl == 4'd0) |-> (irq_vec == '0));                          // R3
endmodule

bind irq_arbiter irq_arb_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psw_mask (psw_mask),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .irq_lvl  (irq_lvl)
);

// File: tb/tb_irq_arbiter.sv
// Bench for irq_arbiter: the driver queues expected outputs, the monitor
// compares them 2 ns after each rising edge.
module tb_irq_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hw_irq = '0;
    logic [3:0] psw_mask = '0;
    logic [4:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_wdata = '0;
    logic       ack = 1'b0;
    logic       irq_req;
    logic [3:0] irq_vec;
    logic [3:0] irq_lvl;

    typedef struct {
        bit    req;
        int    vec;
        int    lvl;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #4 clk = ~clk;

    irq_arbiter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_irq    (hw_irq),
        .psw_mask  (psw_mask),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .ack       (ack),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .irq_lvl   (irq_lvl)
    );

    // Queue an expectation for the next rising edge, then advance one cycle.
    task automatic step(input bit chk, input bit req = 0, input int vec = 0,
                        input int lvl = 0, input string tag = "");
        exp_t e;
        if (chk) begin
            e.req = req; e.vec = vec; e.lvl = lvl; e.tag = tag;
            q.push_back(e);
        end
        @(negedge clk);
        reg_we = 1'b0;
        ack    = 1'b0;
    endtask

    task automatic wr(input int addr, input int data);
        reg_addr  = 5'(addr);
        reg_wdata = 4'(data);
        reg_we    = 1'b1;
        step(0);
    endtask

    // Monitor: compare the outputs against the oldest expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (irq_req !== e.req || int'(irq_vec) != e.vec || int'(irq_lvl) != e.lvl) begin
                    n_fail++;
                    $display("FAIL %s: got req=%0b vec=%0d lvl=%0d, expected req=%0b vec=%0d lvl=%0d",
                             e.tag, irq_req, irq_vec, irq_lvl, e.req, e.vec, e.lvl);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got run still active, expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1, 0, 0, 0, "R1 reset state");

        hw_irq[5] = 1'b1;                                // level source, prio 0
        step(1, 0, 0, 0, "R3 priority 0 disabled");
        wr(5, 3);
        step(1, 1, 5, 3, "R2 R6 level source wins");
        ack = 1'b1;
        step(1, 1, 5, 3, "R6 ack leaves level source");
        psw_mask = 4'd3;
        step(1, 0, 5, 3, "R5 equal level masked");
        psw_mask = 4'd2;
        step(1, 1, 5, 3, "R5 strictly above");
        psw_mask = 4'd0;
        hw_irq[6] = 1'b1;
        wr(6, 3);
        step(1, 1, 5, 3, "R4 tie lower index");
        wr(6, 7);
        step(1, 1, 6, 7, "R4 highest priority");
        hw_irq[6:5] = 2'b00;
        step(1, 0, 0, 0, "R10 drop within one clock");

        wr(2, 9);
        hw_irq[2] = 1'b1;                                // edge source
        step(1, 1, 2, 9, "R10 edge seen in one clock");
        hw_irq[2] = 1'b0;
        step(1, 1, 2, 9, "R7 edge latched");
        ack = 1'b1;
        step(1, 0, 0, 0, "R9 ack clears edge source");

        wr(8, 2);
        wr(9, 5);
        wr(4, 6);
        hw_irq[4] = 1'b1;
        step(1, 1, 4, 6, "R6 level source 4");
        reg_addr = 5'd12; reg_wdata = 4'b0011; reg_we = 1'b1;
        step(1, 1, 4, 6, "R8 hardware above software");
        hw_irq[4] = 1'b0;
        step(1, 1, 9, 5, "R8 posted software wins");
        psw_mask = 4'd5;
        step(1, 0, 9, 5, "R5 software masked");
        psw_mask = 4'd1;
        ack = 1'b1;
        step(1, 1, 9, 5, "R9 ack ignored while idle");
        ack = 1'b1;
        step(1, 1, 8, 2, "R9 ack clears software source");
        reg_addr = 5'd13; reg_wdata = 4'b0001; reg_we = 1'b1;
        step(1, 0, 0, 0, "R8 withdraw");

        psw_mask = 4'd0;
        wr(1, 4);
        hw_irq[1] = 1'b1;
        step(1, 1, 1, 4, "R7 edge source 1");
        hw_irq[1] = 1'b0;
        step(1, 1, 1, 4, "R7 hold after fall");
        hw_irq[1] = 1'b1;
        ack = 1'b1;
        step(1, 1, 1, 4, "R9 new edge beats ack");
        hw_irq[1] = 1'b0;
        ack = 1'b1;
        step(1, 0, 0, 0, "R9 ack after re-arm");

        step(0);
        step(0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule